// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block decides, on every clock cycle, which of several hardware thread contexts feeds the next instruction into one scalar pipeline. Each context has its own program counter and a ready flag, and all of them are kept on chip. Changing from one thread to another therefore costs either nothing or a short bubble, because no state has to be saved or restored. Every selection goes out with the thread's tag, so that downstream stages can tell instructions from different threads apart.

Two scheduling policies are available, and a mode input chooses between them. In interleaved mode the selector moves round-robin to the next ready thread on every cycle and skips any thread that is suspended. In blocked mode it keeps issuing from one thread until the pipeline reports a long-latency event for that thread, such as a remote memory access. The selector then inserts a configurable number of bubble cycles and moves on to the next ready thread.

A thread that has been reported stalled stays suspended until its completion pulse arrives. It then becomes eligible again and continues from the program counter it held when it was suspended.

Top module: `hw_thread_sel`

## Requirements
- R1: After reset every thread is ready, `valid_o` is high, and thread t holds PC = RST_BASE + t*RST_STRIDE (defaults 0x1000 and 0x100). The last-issued pointer starts at the highest thread, so interleaved mode issues thread 0 first and blocked mode issues the highest thread first.
- R2: In interleaved mode (`blocked_mode_i`=0), each cycle issues the first ready thread strictly after the one that issued last, in ascending tag order with wrap-around.
- R3: In interleaved mode, a suspended thread is skipped. If only one thread is ready, it issues on consecutive cycles.
- R4: In blocked mode (`blocked_mode_i`=1), the thread that issued last keeps issuing on every cycle while it is ready.
- R5: In blocked mode, a stall reported for the thread that is issuing in that cycle makes `valid_o` low for SWITCH_PENALTY cycles (default 1). After the bubble, the first ready thread after it in round-robin order issues.
- R6: A completion pulse `done_i[t]` makes thread t ready from the next cycle. The thread then resumes at the PC it held when it was suspended.
- R7: When no thread is ready, `valid_o` is low. It goes high again in the cycle after a completion arrives.
- R8: `redir_i[t]` loads thread t's PC from `redir_pc_i[t*PC_W +: PC_W]` at the next edge. The redirect overrides the +4 advance if thread t issues in the same cycle.
- R9: A stall for thread t (`stall_i`=1, `stall_tag_i`=t) and `done_i[t]` in the same cycle leave thread t suspended.
- R10: `pc_o` is the PC held by the thread named by `tid_o`. An instruction issued in the cycle a stall is reported still issues, and its thread cannot issue in the following cycle.
- R11: A thread's PC advances by 4 only in a cycle where that thread issues. The PCs of the other threads hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| blocked_mode_i | input | 1 | 0 = interleaved, 1 = blocked switching |
| redir_i | input | NUM_THR | Per-thread PC redirect strobe |
| redir_pc_i | input | NUM_THR*PC_W | Redirect targets, thread t in slice t*PC_W |
| stall_i | input | 1 | Long-latency event reported |
| stall_tag_i | input | TAG_W | Thread the event belongs to |
| done_i | input | NUM_THR | Per-thread completion of the outstanding access |
| valid_o | output | 1 | An instruction is issued this cycle |
| tid_o | output | TAG_W | Tag of the issuing thread |
| pc_o | output | PC_W | PC of the issuing thread |

## Verification
The hardest state to reach is the empty schedule: every thread is suspended, and then a single completion arrives in the same cycle as a new stall for the same thread. This is the only situation where the stall-over-completion priority is visible at the ports. The stimulus table gets there by stalling each thread in turn while the round-robin order visits it, so that every context has been retired. It then releases one thread and applies the conflicting pulses to another. The post-conflict cycles show whether the contested thread is ever picked. The blocked-mode bubble and the resume of a suspended PC are reached with a directed sequence that stalls the running thread and later returns to interleaving, so that the saved PC of the suspended thread appears on `pc_o`.

// File: rtl/hw_thr_pkg.sv
package hw_thr_pkg;
  typedef enum logic {
    MODE_INTERLEAVE = 1'b0,
    MODE_BLOCKED    = 1'b1
  } sched_mode_e;

  localparam int unsigned PC_STEP = 4;
endpackage

// File: rtl/thr_rr_pick.sv
module thr_rr_pick #(
  parameter int unsigned NUM_THR = 4,
  parameter int unsigned TAG_W   = $clog2(NUM_THR)
) (
  input  logic [NUM_THR-1:0] req_i,
  input  logic [TAG_W-1:0]   base_i,
  output logic [TAG_W-1:0]   pick_o,
  output logic               found_o
);
  // first requester strictly after base, base itself checked last
  always_comb begin
    pick_o  = base_i;
    found_o = 1'b0;
    for (int unsigned i = 1; i <= NUM_THR; i++) begin
      int unsigned idx;
      idx = (int'(base_i) + i) % NUM_THR;
      if (!found_o && req_i[idx]) begin
        pick_o  = TAG_W'(idx);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/thr_ready_track.sv
module thr_ready_track #(
  parameter int unsigned NUM_THR = 4,
  parameter int unsigned TAG_W   = $clog2(NUM_THR)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stall_i,
  input  logic [TAG_W-1:0]   stall_tag_i,
  input  logic [NUM_THR-1:0] done_i,
  output logic [NUM_THR-1:0] ready_o
);
  logic [NUM_THR-1:0] ready_q;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic hit;
    assign hit = stall_i && (stall_tag_i == TAG_W'(t));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ready_q[t] <= 1'b1;
      else if (hit)       ready_q[t] <= 1'b0;  // stall beats completion
      else if (done_i[t]) ready_q[t] <= 1'b1;
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/thr_pc_bank.sv
module thr_pc_bank
  import hw_thr_pkg::*;
#(
  parameter int unsigned NUM_THR    = 4,
  parameter int unsigned PC_W       = 32,
  parameter logic [31:0] RST_BASE   = 32'h0000_1000,
  parameter logic [31:0] RST_STRIDE = 32'h0000_0100
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_THR-1:0]      redir_i,
  input  logic [NUM_THR*PC_W-1:0] redir_pc_i,
  input  logic [NUM_THR-1:0]      adv_i,
  output logic [NUM_THR*PC_W-1:0] pc_o
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_pc
    localparam logic [31:0] RST_PC = RST_BASE + RST_STRIDE * t;
    logic [PC_W-1:0] pc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pc_q <= PC_W'(RST_PC);
      else if (redir_i[t]) pc_q <= redir_pc_i[t*PC_W +: PC_W];
      else if (adv_i[t])   pc_q <= pc_q + PC_W'(PC_STEP);
    end
    assign pc_o[t*PC_W +: PC_W] = pc_q;
  end
endmodule

// File: rtl/thr_switch_gate.sv
module thr_switch_gate #(
  parameter int unsigned PENALTY = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic hold_o
);
  if (PENALTY == 0) begin : g_free
    assign hold_o = 1'b0;
  end else begin : g_cnt
    localparam int unsigned CW = $clog2(PENALTY + 1);
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               cnt_q <= '0;
      else if (trig_i)           cnt_q <= CW'(PENALTY);
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end
    assign hold_o = (cnt_q != '0);
  end
endmodule

// File: rtl/hw_thread_sel.sv
module hw_thread_sel
  import hw_thr_pkg::*;
#(
  parameter int unsigned NUM_THR        = 4,
  parameter int unsigned PC_W           = 32,
  parameter int unsigned SWITCH_PENALTY = 1,
  parameter logic [31:0] RST_BASE       = 32'h0000_1000,
  parameter logic [31:0] RST_STRIDE     = 32'h0000_0100,
  localparam int unsigned TAG_W         = $clog2(NUM_THR)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    blocked_mode_i,
  input  logic [NUM_THR-1:0]      redir_i,
  input  logic [NUM_THR*PC_W-1:0] redir_pc_i,
  input  logic                    stall_i,
  input  logic [TAG_W-1:0]        stall_tag_i,
  input  logic [NUM_THR-1:0]      done_i,
  output logic                    valid_o,
  output logic [TAG_W-1:0]        tid_o,
  output logic [PC_W-1:0]         pc_o
);
  logic [NUM_THR-1:0]      ready;
  logic [TAG_W-1:0]        last_q, last_d, rr_tid, sel_tid;
  logic                    rr_found, hold, trig;
  logic [NUM_THR-1:0]      adv;
  logic [NUM_THR*PC_W-1:0] pc_flat;
  sched_mode_e             mode;

  assign mode = sched_mode_e'(blocked_mode_i);

  thr_ready_track #(.NUM_THR(NUM_THR), .TAG_W(TAG_W)) u_ready (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stall_i    (stall_i),
    .stall_tag_i(stall_tag_i),
    .done_i     (done_i),
    .ready_o    (ready)
  );

  thr_rr_pick #(.NUM_THR(NUM_THR), .TAG_W(TAG_W)) u_pick (
    .req_i  (ready),
    .base_i (last_q),
    .pick_o (rr_tid),
    .found_o(rr_found)
  );

  thr_switch_gate #(.PENALTY(SWITCH_PENALTY)) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig),
    .hold_o(hold)
  );

  always_comb begin
    sel_tid = rr_tid;
    if (mode == MODE_BLOCKED && ready[last_q]) sel_tid = last_q;
  end

  assign valid_o = rr_found && !hold;
  assign last_d  = valid_o ? sel_tid : last_q;
  // blocked mode: the running thread hit a long-latency event
  assign trig    = (mode == MODE_BLOCKED) && stall_i && (stall_tag_i == last_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= TAG_W'(NUM_THR - 1);
    else         last_q <= last_d;
  end

  always_comb begin
    adv = '0;
    if (valid_o) adv[sel_tid] = 1'b1;
  end

  thr_pc_bank #(
    .NUM_THR   (NUM_THR),
    .PC_W      (PC_W),
    .RST_BASE  (RST_BASE),
    .RST_STRIDE(RST_STRIDE)
  ) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .redir_i   (redir_i),
    .redir_pc_i(redir_pc_i),
    .adv_i     (adv),
    .pc_o      (pc_flat)
  );

  assign tid_o = sel_tid;
  assign pc_o  = pc_flat[sel_tid*PC_W +: PC_W];
endmodule

// File: rtl/hw_thread_sel_chk.sv
module hw_thread_sel_chk #(
  parameter int unsigned NUM_THR        = 4,
  parameter int unsigned PC_W           = 32,
  parameter int unsigned SWITCH_PENALTY = 1,
  parameter int unsigned TAG_W          = $clog2(NUM_THR)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    blocked_mode_i,
  input logic [NUM_THR-1:0]      redir_i,
  input logic [NUM_THR*PC_W-1:0] redir_pc_i,
  input logic                    stall_i,
  input logic [TAG_W-1:0]        stall_tag_i,
  input logic [NUM_THR-1:0]      done_i,
  input logic                    valid_o,
  input logic [TAG_W-1:0]        tid_o,
  input logic [PC_W-1:0]         pc_o
);
  p_stalled_not_next_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !(valid_o && tid_o == $past(stall_tag_i)));

  p_stall_beats_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && done_i[stall_tag_i]) |=> !(valid_o && tid_o == $past(stall_tag_i)));

  p_pc_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !redir_i[tid_o]) |=>
      (!(valid_o && tid_o == $past(tid_o)) || pc_o == $past(pc_o) + PC_W'(4)));

  p_blocked_stays_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked_mode_i && valid_o && !stall_i) ##1 (blocked_mode_i && valid_o)
      |-> tid_o == $past(tid_o));

  if (SWITCH_PENALTY > 0) begin : g_pen
    p_bubble_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blocked_mode_i && valid_o && stall_i && stall_tag_i == tid_o) |=> !valid_o);
  end

  for (genvar k = 0; k < NUM_THR; k++) begin : g_redir
    p_redir_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      redir_i[k] |=>
        (!(valid_o && tid_o == TAG_W'(k)) || pc_o == $past(redir_pc_i[k*PC_W +: PC_W])));
  end
endmodule

bind hw_thread_sel hw_thread_sel_chk #(
  .NUM_THR       (NUM_THR),
  .PC_W          (PC_W),
  .SWITCH_PENALTY(SWITCH_PENALTY),
  .TAG_W         (TAG_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .blocked_mode_i(blocked_mode_i),
  .redir_i       (redir_i),
  .redir_pc_i    (redir_pc_i),
  .stall_i       (stall_i),
  .stall_tag_i   (stall_tag_i),
  .done_i        (done_i),
  .valid_o       (valid_o),
  .tid_o         (tid_o),
  .pc_o          (pc_o)
);

// File: tb/hw_thread_sel_tb_top.sv
module hw_thread_sel_tb_top;
  localparam int NT = 4;
  localparam int PW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            mode;
  logic [NT-1:0]   redir;
  logic [NT*PW-1:0] redir_pc;
  logic            stall;
  logic [1:0]      stag;
  logic [NT-1:0]   done;
  logic            valid;
  logic [1:0]      tid;
  logic [PW-1:0]   pc;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  hw_thread_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .blocked_mode_i(mode), .redir_i(redir),
    .redir_pc_i(redir_pc), .stall_i(stall), .stall_tag_i(stag), .done_i(done),
    .valid_o(valid), .tid_o(tid), .pc_o(pc)
  );

  // row: mode | stall | tag[1:0] | done[3:0] | exp_valid | exp_tid[1:0]
  localparam int NV = 31;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0,1'b0,2'd0,4'b0000,1'b1,2'd0},  // 0  R2
    {1'b0,1'b0,2'd0,4'b0000,1'b1,2'd1},  // 1  R2
    {1'b0,1'b1,2'd2,4'b0000,1'b1,2'd2},  // 2  R10 issues while stalled
    {1'b0,1'b0,2'd0,4'b0000,1'b1,2'd3},  // 3
    {1'b0,1'b0,2'd0,4'b0000,1'b1,2'd0},  // 4
    {1'b0,1'b0,2'd0,4'b0000,1'b1,2'd1},  // 5
    {1'b0,1'b0,2'd0,4'b0000,1'b1,2'd3},  // 6  R3 skip 2
    {1'b0,1'b0,2'd0,4'b0100,1'b1,2'd0},  // 7  R6 release 2
    {1'b0,1'b0,2'd0,4'b0000,1'b1,2'd1},  // 8
    {1'b0,1'b0,2'd0,4'b0000,1'b1,2'd2},  // 9  R6
    {1'b0,1'b1,2'd0,4'b0000,1'b1,2'd3},  // 10
    {1'b0,1'b1,2'd1,4'b0000,1'b1,2'd1},  // 11 R3
    {1'b0,1'b1,2'd2,4'b0000,1'b1,2'd2},  // 12
    {1'b0,1'b1,2'd3,4'b0000,1'b1,2'd3},  // 13
    {1'b0,1'b0,2'd0,4'b0000,1'b0,2'd0},  // 14 R7 none ready
    {1'b0,1'b0,2'd0,4'b0010,1'b0,2'd0},  // 15 R7
    {1'b0,1'b0,2'd0,4'b0000,1'b1,2'd1},  // 16 R7 recover
    {1'b0,1'b1,2'd0,4'b0001,1'b1,2'd1},  // 17 R9 conflict on 0
    {1'b0,1'b0,2'd0,4'b0000,1'b1,2'd1},  // 18 R9 0 still out
    {1'b0,1'b0,2'd0,4'b1101,1'b1,2'd1},  // 19
    {1'b0,1'b0,2'd0,4'b0000,1'b1,2'd2},  // 20
    {1'b1,1'b0,2'd0,4'b0000,1'b1,2'd2},  // 21 R4
    {1'b1,1'b0,2'd0,4'b0000,1'b1,2'd2},  // 22 R4
    {1'b1,1'b1,2'd2,4'b0000,1'b1,2'd2},  // 23 R5
    {1'b1,1'b0,2'd0,4'b0000,1'b0,2'd0},  // 24 R5 bubble
    {1'b1,1'b0,2'd0,4'b0000,1'b1,2'd3},  // 25 R5
    {1'b1,1'b0,2'd0,4'b0000,1'b1,2'd3},  // 26 R4
    {1'b1,1'b0,2'd0,4'b0100,1'b1,2'd3},  // 27 R4
    {1'b1,1'b0,2'd0,4'b0000,1'b1,2'd3},  // 28
    {1'b0,1'b0,2'd0,4'b0000,1'b1,2'd0},  // 29 R2
    {1'b0,1'b0,2'd0,4'b0000,1'b1,2'd1}   // 30 R2
  };

  task automatic clear_pulses();
    stall = 1'b0; stag = '0; done = '0; redir = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mode = 1'b0; clear_pulses(); redir_pc = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check(input logic ev, input logic [1:0] et, input logic [PW-1:0] epc,
                       input bit use_pc, input string req);
    tests++;
    if (valid !== ev || (ev && tid !== et) || (ev && use_pc && pc !== epc)) begin
      fails++;
      $display("FAIL %s: got valid=%0b tid=%0d pc=%h, expected valid=%0b tid=%0d pc=%h",
               req, valid, tid, pc, ev, et, epc);
    end
  endtask

  task automatic next();
    @(negedge clk);
    clear_pulses();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) begin
      mode  = VEC[i][10];
      stall = VEC[i][9];
      stag  = VEC[i][8:7];
      done  = VEC[i][6:3];
      #1;
      check(VEC[i][2], VEC[i][1:0], '0, 1'b0, $sformatf("table row %0d", i));
      next();
    end

    // R1 reset state, R8 redirect, R11 advance
    do_reset();
    #1 check(1'b1, 2'd0, 32'h1000, 1'b1, "R1 reset thread 0");
    redir[0] = 1'b1; redir_pc[0 +: PW] = 32'h2000;
    next();
    #1 check(1'b1, 2'd1, 32'h1100, 1'b1, "R1 thread 1 start pc");
    redir[2] = 1'b1; redir_pc[2*PW +: PW] = 32'h3000;
    next();
    #1 check(1'b1, 2'd2, 32'h3000, 1'b1, "R8 redirect idle thread");
    next();
    #1 check(1'b1, 2'd3, 32'h1300, 1'b1, "R1 thread 3 start pc");
    next();
    #1 check(1'b1, 2'd0, 32'h2000, 1'b1, "R8 redirect beats advance");
    next();
    #1 check(1'b1, 2'd1, 32'h1104, 1'b1, "R11 single advance");
    next();
    #1 check(1'b1, 2'd2, 32'h3004, 1'b1, "R11 advance after redirect");

    // R4 R5 R6 blocked run, bubble, resume
    do_reset();
    mode = 1'b1;
    #1 check(1'b1, 2'd3, 32'h1300, 1'b1, "R4 blocked start");
    next();
    stall = 1'b1; stag = 2'd3;
    #1 check(1'b1, 2'd3, 32'h1304, 1'b1, "R4 blocked repeat");
    next();
    #1 check(1'b0, 2'd0, '0, 1'b0, "R5 switch bubble");
    next();
    #1 check(1'b1, 2'd0, 32'h1000, 1'b1, "R5 next thread after bubble");
    done[3] = 1'b1; mode = 1'b0;
    next();
    #1 check(1'b1, 2'd1, 32'h1100, 1'b1, "R2 back to interleave");
    next();
    #1 check(1'b1, 2'd2, 32'h1200, 1'b1, "R2 interleave");
    next();
    #1 check(1'b1, 2'd3, 32'h1308, 1'b1, "R6 resume saved pc");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule